// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block produces the pixel-rate and bit-rate timing for a display pipeline. It does not switch real clocks. It runs on one fast reference clock and receives one enable strobe per candidate source: the bus clock, two display clocks and an HDMI PLL clock. One strobe is selected, and the block divides that strobe stream by a divisor made of an integer part plus a 12-bit fraction. The result is a pixel enable stream. The same selected strobes also feed a small integer divider for a bit-rate enable, and that divider can be bypassed or switched off.

A single 32-bit control word sets all behaviour. While the pixel path runs, a new word waits and takes effect at the next pixel period boundary, so every period is whole. While the path is disabled, a new word takes effect at once. Both outputs are one-cycle pulses on the reference clock. A status output shows whether the pixel path is running.

Top module: `pixclk_gen`

## Requirements
- R1: After reset the control word is 0x10000000: the pixel path is disabled, the bit divisor is 0, and `pix_run`, `pix_en` and `bit_en` are all low.
- R2: Bits 7:0 hold the integer pixel divisor N. With a zero fraction, `pix_en` pulses once every N selected strobes. Values 0 and 1 behave as 2.
- R3: Bits 27:16 hold a fraction F. Each period boundary adds F to a 12-bit phase accumulator, and a carry out of it makes the following period one strobe longer. This gives an average ratio of N + F/4096. The first period after a start or a source change is never stretched.
- R4: While bit 28 is 1, `pix_run` is low and no `pix_en` pulse occurs, whatever the strobes do.
- R5: Bits 31:30 pick the strobe that is counted: 0 is `src_tick[0]` (bus clock), 1 is `src_tick[1]` (display clock 1), 2 is `src_tick[2]` (display clock 2), and 3 is `src_tick[3]` (HDMI PLL). Strobes on the other inputs are ignored.
- R6: Bits 11:8 hold the bit divisor M. For M from 2 to 15, `bit_en` pulses every M selected strobes. M=1 passes every selected strobe through. M=0 keeps `bit_en` low. The bit path does not depend on bit 28.
- R7: While the path runs, a write is held and becomes active at the next pixel boundary. A write on the boundary cycle itself is taken at that boundary, and the latest write wins. While the path is disabled, a write becomes active on the next cycle. Loading any word restarts the bit divider.
- R8: When a word loaded at a boundary selects a different source, the phase accumulator and the stretch flag are cleared, not advanced.
- R9: Each output pulse lasts exactly one cycle. It appears on the cycle after the clock edge at which the qualifying selected strobe was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| src_tick | input | 4 | One enable strobe per candidate source, indexed by the select code |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word being written |
| pix_en | output | 1 | Pixel clock enable pulse |
| bit_en | output | 1 | Bit clock enable pulse |
| pix_run | output | 1 | High while the active word leaves the pixel path enabled |

## Verification
The bench checks several corner cases, each against the fault it would expose:
- Integer fields of 0 and 1: an unclamped divider would fire on every strobe or never.
- A half-step fraction: it must stretch every second period after the first. A wrong accumulator seed or carry timing shifts the pulse count.
- A write that lands before a boundary: it must leave the current period intact, so a design that loads early shortens that period.
- A write on the boundary cycle: it must be taken at once, not one period late.
- Source changes at a boundary, with a nonzero fraction: these expose a stale accumulator.
- The bit divider: it is driven through the off, bypass and divide codes.
- Strobes on unselected inputs: these show whether the select decode is mis-wired.

// File: rtl/pcg_pkg.sv
`timescale 1ns/1ps
package pcg_pkg;
  localparam int NSRC   = 4;
  localparam int SEL_W  = $clog2(NSRC);
  localparam int CFG_W  = 32;
  localparam int IDIV_W = 8;
  localparam int BDIV_W = 4;
  localparam int FRAC_W = 12;

  // decoded fields of the control word (reserved bits are not stored)
  typedef struct packed {
    logic [SEL_W-1:0]  src;
    logic              off;
    logic [FRAC_W-1:0] frac;
    logic [BDIV_W-1:0] bdiv;
    logic [IDIV_W-1:0] idiv;
  } pcg_cfg_t;

  localparam pcg_cfg_t CFG_RESET = '{src: '0, off: 1'b1, frac: '0, bdiv: '0, idiv: '0};
endpackage

// File: rtl/pcg_cfg_shadow.sv
`timescale 1ns/1ps
// Holds the active control word plus one pending word that waits for a
// pixel boundary while the path runs.
module pcg_cfg_shadow import pcg_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  pcg_cfg_t          wr_word,
  input  logic              boundary,
  output pcg_cfg_t          act,
  output logic              upd_avail,
  output logic [SEL_W-1:0]  upd_src,
  output logic [FRAC_W-1:0] upd_frac,
  output logic              load
);
  pcg_cfg_t act_q, act_d, pend_q, pend_d, upd_word;
  logic     pv_q, pv_d;

  always_comb begin
    act_d     = act_q;
    pend_d    = pend_q;
    pv_d      = pv_q;
    load      = 1'b0;
    upd_word  = wr_en ? wr_word : pend_q;   // latest write wins
    upd_avail = wr_en | pv_q;
    if (act_q.off) begin
      if (wr_en) begin
        act_d = wr_word;
        load  = 1'b1;
      end
    end else if (boundary && upd_avail) begin
      act_d = upd_word;
      pv_d  = 1'b0;
      load  = 1'b1;
    end else if (wr_en) begin
      pend_d = wr_word;
      pv_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= CFG_RESET;
      pend_q <= CFG_RESET;
      pv_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  assign act      = act_q;
  assign upd_src  = upd_word.src;
  assign upd_frac = upd_word.frac;
endmodule

// File: rtl/pcg_frac_div.sv
`timescale 1ns/1ps
// Integer-plus-fraction strobe divider. A carry out of the phase
// accumulator lengthens the next period by one strobe.
module pcg_frac_div #(
  parameter int IW = 8,
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [IW-1:0] idiv,
  input  logic [FW-1:0] frac_nxt,
  input  logic          clr_acc,
  output logic          boundary
);
  localparam int CW = IW + 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic [IW-1:0] eff;
  logic [FW-1:0] acc_q, acc_d;
  logic          str_q, str_d;

  always_comb begin
    eff      = (idiv < IW'(2)) ? IW'(2) : idiv;
    lim      = {1'b0, eff} + CW'(str_q) - CW'(1);
    boundary = run & tick & (cnt_q >= lim);
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    str_d    = str_q;
    if (!run) begin
      cnt_d = '0;
      acc_d = '0;
      str_d = 1'b0;
    end else if (boundary) begin
      cnt_d = '0;
      if (clr_acc) begin
        acc_d = '0;
        str_d = 1'b0;
      end else begin
        {str_d, acc_d} = {1'b0, acc_q} + {1'b0, frac_nxt};
      end
    end else if (tick) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      str_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      str_q <= str_d;
    end
  end
endmodule

// File: rtl/pcg_int_div.sv
`timescale 1ns/1ps
// Small strobe divider: 0 off, 1 bypass, 2 and up divide.
module pcg_int_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] div,
  output logic         fire
);
  logic [W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim = div - W'(1);
    if (div == '0)          fire = 1'b0;
    else if (div == W'(1))  fire = tick;
    else                    fire = tick && (cnt_q >= lim);
    cnt_d = cnt_q;
    if (clr || (div < W'(2))) cnt_d = '0;
    else if (tick)            cnt_d = fire ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pixclk_gen.sv
`timescale 1ns/1ps
module pixclk_gen import pcg_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             pix_en,
  output logic             bit_en,
  output logic             pix_run
);
  pcg_cfg_t          wr_word, act;
  logic              upd_avail, load, boundary, q, clr_acc, bfire, run;
  logic [SEL_W-1:0]  upd_src;
  logic [FRAC_W-1:0] upd_frac, frac_nxt;
  logic              pix_en_d, bit_en_d;
  logic              unused_rsv;

  // field positions of the control word
  assign wr_word = '{src:  cfg_wdata[31:30],
                     off:  cfg_wdata[28],
                     frac: cfg_wdata[27:16],
                     bdiv: cfg_wdata[11:8],
                     idiv: cfg_wdata[7:0]};
  assign unused_rsv = ^{cfg_wdata[29], cfg_wdata[15:12]};

  pcg_cfg_shadow u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_word(wr_word),
    .boundary(boundary), .act(act), .upd_avail(upd_avail),
    .upd_src(upd_src), .upd_frac(upd_frac), .load(load)
  );

  assign q        = src_tick[act.src];
  assign run      = ~act.off;
  assign frac_nxt = upd_avail ? upd_frac : act.frac;
  assign clr_acc  = upd_avail && (upd_src != act.src);

  pcg_frac_div #(.IW(IDIV_W), .FW(FRAC_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(q), .idiv(act.idiv),
    .frac_nxt(frac_nxt), .clr_acc(clr_acc), .boundary(boundary)
  );

  pcg_int_div #(.W(BDIV_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .tick(q), .clr(load), .div(act.bdiv),
    .fire(bfire)
  );

  always_comb begin
    pix_en_d = boundary;
    bit_en_d = bfire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_en <= 1'b0;
      bit_en <= 1'b0;
    end else begin
      pix_en <= pix_en_d;
      bit_en <= bit_en_d;
    end
  end

  assign pix_run = run;
endmodule

// File: rtl/pixclk_gen_chk.sv
`timescale 1ns/1ps
module pixclk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] src_tick,
  input logic       cfg_wr,
  input logic       pix_en,
  input logic       bit_en,
  input logic       pix_run
);
  a_r4_off_no_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_run |=> !pix_en);

  a_r9_pix_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> !pix_en);

  a_r9_pix_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> $past(|src_tick));

  a_r6_bit_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> $past(|src_tick));

  a_r7_start_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_run) |-> $past(cfg_wr));

  a_r7_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_run) |-> pix_en);
endmodule

bind pixclk_gen pixclk_gen_chk u_pixclk_gen_chk (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_wr(cfg_wr),
  .pix_en(pix_en), .bit_en(bit_en), .pix_run(pix_run)
);

// File: tb/test_pixclk_gen.sv
`timescale 1ns/1ps
module test_pixclk_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  tick;
  logic        wr;
  logic [31:0] wd;
  logic        pix_en, bit_en, pix_run;

  always #2 clk = ~clk;   // 250 MHz

  pixclk_gen i_pixclk_gen (
    .clk(clk), .rst_n(rst_n), .src_tick(tick), .cfg_wr(wr),
    .cfg_wdata(wd), .pix_en(pix_en), .bit_en(bit_en), .pix_run(pix_run)
  );

  int    n_chk = 0, n_err = 0, cnt_pix = 0, cnt_bit = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic [31:0] m_act, m_pend;
  bit          m_pv;
  int          left, phase, extra, bleft;
  bit          e_pix, e_bit, e_run;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic model_reset();
    m_act = 32'h1000_0000; m_pend = '0; m_pv = 0;
    left = 0; phase = 0; extra = 0; bleft = 0;
    e_pix = 0; e_bit = 0; e_run = 0;
  endtask

  task automatic model(input bit we, input logic [31:0] d, input logic [3:0] tk);
    int sel, bd;
    bit off, q, fire, bf, loaded;
    logic [31:0] nw;
    sel = int'(m_act[31:30]); off = m_act[28]; bd = int'(m_act[11:8]);
    q = tk[sel]; fire = 0; bf = 0; loaded = 0; nw = m_act;
    if (!off && q) begin
      left--;
      if (left == 0) fire = 1;
    end
    if (bd == 1) bf = q;
    else if (bd >= 2 && q) begin
      bleft--;
      if (bleft == 0) begin bf = 1; bleft = bd; end
    end
    if (off) begin
      if (we) begin
        nw = d; loaded = 1; phase = 0; extra = 0;
        m_act = nw; left = eff(int'(nw[7:0]));
      end
    end else if (fire) begin
      loaded = we || m_pv;
      nw = we ? d : (m_pv ? m_pend : m_act);
      if (loaded && nw[31:30] != m_act[31:30]) begin
        phase = 0; extra = 0;
      end else begin
        phase += int'(nw[27:16]);
        extra = (phase >= 4096);
        if (extra != 0) phase -= 4096;
      end
      m_pv = 0; m_act = nw;
      left = eff(int'(nw[7:0])) + extra;
    end else if (we) begin
      m_pend = d; m_pv = 1;
    end
    if (loaded) bleft = int'(nw[11:8]);
    e_pix = fire; e_bit = bf; e_run = !m_act[28];
  endtask

  task automatic cyc(input bit we, input logic [31:0] d, input logic [3:0] tk);
    wr = we; wd = d; tick = tk;
    model(we, d, tk);
    @(posedge clk); #1;
    check(pix_en === e_pix, cur_req, "pix_en", int'(pix_en), int'(e_pix));
    check(bit_en === e_bit, cur_req, "bit_en", int'(bit_en), int'(e_bit));
    check(pix_run === e_run, cur_req, "pix_run", int'(pix_run), int'(e_run));
    if (pix_en) cnt_pix++;
    if (bit_en) cnt_bit++;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [3:0] tk);
    for (int i = 0; i < n; i++) cyc(1'b0, 32'h0, tk);
  endtask

  // stop the path at its next boundary, then confirm it is off
  task automatic go_off();
    cyc(1'b1, 32'h1000_0000, 4'hF);
    idle(300, 4'hF);
    check(pix_run === 1'b0, "R4", "pix_run after stop", int'(pix_run), 0);
  endtask

  task automatic start(input logic [31:0] w, input logic [3:0] tk);
    cyc(1'b1, w, tk);
    cnt_pix = 0; cnt_bit = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; wd = '0; tick = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pix_run === 1'b0, "R1", "pix_run in reset", int'(pix_run), 0);
    check(pix_en === 1'b0, "R1", "pix_en in reset", int'(pix_en), 0);
    check(bit_en === 1'b0, "R1", "bit_en in reset", int'(bit_en), 0);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(10, 4'hF);

    // R2 and R7 (immediate load from disabled): divide by 4
    cur_req = "R2";
    start(32'h4000_0004, 4'b0010);
    idle(40, 4'b0010);
    check(cnt_pix == 10, "R2", "pulses at N=4", cnt_pix, 10);
    go_off();

    // R2: integer field 1 clamps to 2
    start(32'h4000_0001, 4'b0010);
    idle(40, 4'b0010);
    check(cnt_pix == 20, "R2", "pulses at N=1 clamp", cnt_pix, 20);
    go_off();
    start(32'h4000_0000, 4'b0010);
    idle(40, 4'b0010);
    check(cnt_pix == 20, "R2", "pulses at N=0 clamp", cnt_pix, 20);
    go_off();

    // R3: N=2, F=2048 -> periods 2,2,3,2,3,...
    cur_req = "R3";
    start(32'h4800_0002, 4'b0010);
    idle(40, 4'b0010);
    check(cnt_pix == 16, "R3", "pulses at 2.5", cnt_pix, 16);
    go_off();

    // R4: disabled word with strobes everywhere
    cur_req = "R4";
    start(32'h1000_0003, 4'hF);
    idle(30, 4'hF);
    check(cnt_pix == 0, "R4", "pulses while disabled", cnt_pix, 0);
    check(pix_run === 1'b0, "R4", "pix_run while disabled", int'(pix_run), 0);

    // R5: source 2 selected, other strobes ignored
    cur_req = "R5";
    start(32'h8000_0003, 4'b1011);
    idle(30, 4'b1011);
    check(cnt_pix == 0, "R5", "pulses from unselected strobes", cnt_pix, 0);
    check(pix_run === 1'b1, "R5", "pix_run", int'(pix_run), 1);
    cnt_pix = 0;
    idle(30, 4'b0100);
    check(cnt_pix == 10, "R5", "pulses from source 2", cnt_pix, 10);
    go_off();

    // R6: bit divider bypass, divide, off
    cur_req = "R6";
    start(32'hD000_0102, 4'b1000);
    idle(30, 4'b1000);
    check(cnt_bit == 30, "R6", "bit bypass", cnt_bit, 30);
    start(32'h0000_0502, 4'b0001);
    idle(30, 4'b0001);
    check(cnt_bit == 6, "R6", "bit divide 5", cnt_bit, 6);
    go_off();
    start(32'h0000_0002, 4'b0001);
    idle(30, 4'b0001);
    check(cnt_bit == 0, "R6", "bit off", cnt_bit, 0);
    go_off();

    // R7: write mid-period waits for the boundary
    cur_req = "R7";
    start(32'h4000_0004, 4'b0010);
    cnt_pix = 0;
    idle(2, 4'b0010);
    cyc(1'b1, 32'h4000_0002, 4'b0010);
    idle(37, 4'b0010);
    check(cnt_pix == 19, "R7", "pulses across deferred update", cnt_pix, 19);

    // R8: source changes at boundaries with a fraction in use
    cur_req = "R8";
    cyc(1'b1, 32'h4C00_0003, 4'hF);
    idle(25, 4'hF);
    cyc(1'b1, 32'hCC00_0002, 4'hF);
    idle(25, 4'hF);
    cyc(1'b1, 32'h0400_0102, 4'hF);
    idle(25, 4'hF);
    go_off();

    // R9: random strobes and writes, compared against the model each cycle
    cur_req = "R9";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      bit we;
      we = ($urandom_range(0, 24) == 0);
      w = {2'($urandom_range(0, 3)), 1'b0, 1'($urandom_range(0, 7) == 0),
           12'($urandom), 4'b0, 4'($urandom_range(0, 6)),
           8'($urandom_range(0, 6))};
      cyc(we, w, 4'($urandom));
    end

    finish_run();
  end
endmodule